// File: doc/BRIEF.md
# Byte-Lane Steering Unit

This unit sits between a 16-bit host data bus and an internal buffer RAM. The RAM is organised as two byte banks, one for even byte addresses and one for odd byte addresses, sharing a word address. A control byte selects narrow (8-bit) or wide (16-bit) transfers. A separately written pointer supplies the RAM address. In narrow mode every pointer bit is part of the address, and only the lower host lane carries data. In wide mode the pointer's least significant bit stops being an address bit and becomes a lane-swap control. Each access then moves one even/odd byte pair.

In wide mode, the bank that appears on each host lane depends on two things: the host bus style (separate read/write strobes, or a direction signal plus a data strobe) and the swap control. The unit generates the per-lane output enables. The upper lane is released to high impedance whenever it is not carrying RAM read data. The unit also drives an active-low 16-bit access indication for wide CPU accesses to RAM. DMA cycles are steered exactly like CPU cycles but never assert that indication. Host bus style detection, DMA sequencing and the RAM itself are outside the block.

Top module: `byte_lane_steer`

## Requirements
- R1: After reset the unit is in narrow mode with the pointer at zero. With no access in progress, both lane enables are low, `io16_n` is high and neither bank write enable is asserted.
- R2: On `ctl_wr`, bit 7 of `ctl_wdata` is loaded as the mode: 1 selects wide, 0 selects narrow. The other control bits have no effect.
- R3: In narrow mode `ram_addr` is pointer bits [ADDR_W-1:1]. A RAM read places the odd bank on `hd_out[7:0]` when pointer bit 0 is 1, and the even bank when it is 0. The upper lane enable stays low.
- R4: In a narrow RAM write, `hd_in[7:0]` is written only into the bank selected by pointer bit 0. The other bank is not written.
- R5: In wide mode, pointer bit 0 is the swap control and not an address bit. `ram_addr` is pointer bits [ADDR_W-1:1]. A RAM write writes both banks.
- R6: With `host_style` = 0 (separate strobes) in wide mode, the even bank uses the lower lane and the odd bank the upper lane when swap is 0. Swap = 1 exchanges them. This holds for reads and for writes.
- R7: With `host_style` = 1 (direction plus strobe) in wide mode, the odd bank uses the lower lane and the even bank the upper lane when swap is 0. Swap = 1 exchanges them. This holds for reads and for writes.
- R8: `hd_lo_oe` is high exactly during a RAM read. `hd_hi_oe` is high exactly during a RAM read in wide mode. Each lane of `hd_out` is zero while its enable is low.
- R9: `io16_n` is low exactly when wide mode is on, `acc_ram` is high, a read or write strobe is active and `acc_dma` is low.
- R10: DMA cycles (`acc_dma` = 1) use the same lane routing, bank enables and address as CPU cycles.
- R11: An access with `acc_ram` = 0 asserts no bank write enable and no lane enable.
- R12: If `acc_rd` and `acc_wr` are both high, the access is a read and no bank is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Load control byte |
| ctl_wdata | input | 8 | Control byte; bit 7 selects wide mode |
| ptr_wr | input | 1 | Load RAM pointer |
| ptr_wdata | input | ADDR_W | Pointer value |
| host_style | input | 1 | Detected host style: 0 separate strobes, 1 direction plus strobe |
| acc_rd | input | 1 | Read strobe valid |
| acc_wr | input | 1 | Write strobe valid |
| acc_ram | input | 1 | Access targets the buffer RAM |
| acc_dma | input | 1 | Access is a DMA cycle |
| hd_in | input | 16 | Host data from both lanes |
| hd_out | output | 16 | Host data to both lanes |
| hd_lo_oe | output | 1 | Lower lane output enable |
| hd_hi_oe | output | 1 | Upper lane output enable (low means high impedance) |
| io16_n | output | 1 | Active-low 16-bit CPU access indication |
| ram_addr | output | ADDR_W-1 | RAM word address |
| ram_we_even | output | 1 | Even bank write enable |
| ram_we_odd | output | 1 | Odd bank write enable |
| ram_wdata_even | output | 8 | Even bank write data |
| ram_wdata_odd | output | 8 | Odd bank write data |
| ram_rdata_even | input | 8 | Even bank read data |
| ram_rdata_odd | input | 8 | Odd bank read data |

## Verification
The bench fills the RAM with an arithmetic pattern and then sweeps every combination of host style, swap value and DMA flag over words at both ends of the address range. It covers wide and narrow modes, recomputing in each case which byte address should appear on each lane. A design that ignores the host style or the swap bit puts the wrong bank on a lane, and a read of a pair of unequal bytes shows the error. A design that keeps pointer bit 0 as an address bit in wide mode writes the wrong word. Further cases cover a DMA cycle that wrongly pulls the 16-bit indication low, a narrow write that spills into the neighbouring bank, an access to a non-RAM target, and a read and write strobe that arrive together. Each of these shows up as a wrong indication level or as corrupted RAM contents.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic {
    STYLE_STROBES = 1'b0,
    STYLE_DIRDS   = 1'b1
  } host_style_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ram;
    logic dma;
  } acc_t;

  // Which bank the lower host lane carries.
  // Wide: fixed by host style, flipped by swap. Narrow: the bank picked by the byte select.
  function automatic logic lower_is_even(host_style_e st, logic wide, logic swap, logic bsel);
    if (wide) return (st == STYLE_STROBES) ^ swap;
    return ~bsel;
  endfunction

  function automatic logic read_fires(acc_t a);
    return a.rd & a.ram;
  endfunction

  // A simultaneous read strobe wins over the write strobe.
  function automatic logic write_fires(acc_t a);
    return a.wr & ~a.rd & a.ram;
  endfunction

  function automatic logic wide_cpu_cycle(acc_t a, logic wide);
    return wide & a.ram & (a.rd | a.wr) & ~a.dma;
  endfunction

endpackage

// File: rtl/lsu_cfg_regs.sv
module lsu_cfg_regs #(
  parameter int ADDR_W   = 11,
  parameter int CTL_W    = 8,
  parameter int WIDE_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              ptr_wr,
  input  logic [ADDR_W-1:0] ptr_wdata,
  output logic              wide_o,
  output logic              swap_o,
  output logic              bsel_o,
  output logic [ADDR_W-2:0] word_addr_o
);

  localparam int WORD_AW = ADDR_W - 1;

  logic              wide_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              unused_ctl_bits;

  assign unused_ctl_bits = ^(ctl_wdata & ~(CTL_W'(1) << WIDE_BIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wide_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      if (ctl_wr) wide_q <= ctl_wdata[WIDE_BIT];
      if (ptr_wr) ptr_q  <= ptr_wdata;
    end
  end

  // Bit 0 is a swap control in wide mode and a byte select in narrow mode.
  assign wide_o      = wide_q;
  assign swap_o      = wide_q & ptr_q[0];
  assign bsel_o      = ~wide_q & ptr_q[0];
  assign word_addr_o = ptr_q[ADDR_W-1:ADDR_W-WORD_AW];

endmodule

// File: rtl/lsu_read_steer.sv
module lsu_read_steer #(
  parameter int BYTE_W = 8
) (
  input  logic                rd_fire,
  input  logic                wide,
  input  logic                lo_even,
  input  logic [BYTE_W-1:0]   rdata_even,
  input  logic [BYTE_W-1:0]   rdata_odd,
  output logic [2*BYTE_W-1:0] dout,
  output logic                lo_oe,
  output logic                hi_oe
);

  logic [BYTE_W-1:0] lo_sel;
  logic [BYTE_W-1:0] hi_sel;

  always_comb begin
    lo_sel = lo_even ? rdata_even : rdata_odd;
    hi_sel = lo_even ? rdata_odd  : rdata_even;
    lo_oe  = rd_fire;
    hi_oe  = rd_fire & wide;
    dout   = '0;
    if (lo_oe) dout[BYTE_W-1:0]        = lo_sel;
    if (hi_oe) dout[2*BYTE_W-1:BYTE_W] = hi_sel;
  end

endmodule

// File: rtl/lsu_write_steer.sv
module lsu_write_steer #(
  parameter int BYTE_W = 8
) (
  input  logic                wr_fire,
  input  logic                wide,
  input  logic                lo_even,
  input  logic [2*BYTE_W-1:0] din,
  output logic                we_even,
  output logic                we_odd,
  output logic [BYTE_W-1:0]   wdata_even,
  output logic [BYTE_W-1:0]   wdata_odd
);

  logic [BYTE_W-1:0] din_lo;
  logic [BYTE_W-1:0] din_hi;

  assign din_lo = din[BYTE_W-1:0];
  assign din_hi = din[2*BYTE_W-1:BYTE_W];

  always_comb begin
    we_even    = wr_fire & (wide | lo_even);
    we_odd     = wr_fire & (wide | ~lo_even);
    wdata_even = (wide & ~lo_even) ? din_hi : din_lo;
    wdata_odd  = (wide &  lo_even) ? din_hi : din_lo;
  end

endmodule

// File: rtl/byte_lane_steer.sv
module byte_lane_steer
  import lsu_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int BYTE_W   = 8,
  parameter int WIDE_BIT = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_wr,
  input  logic [7:0]          ctl_wdata,
  input  logic                ptr_wr,
  input  logic [ADDR_W-1:0]   ptr_wdata,
  input  logic                host_style,
  input  logic                acc_rd,
  input  logic                acc_wr,
  input  logic                acc_ram,
  input  logic                acc_dma,
  input  logic [2*BYTE_W-1:0] hd_in,
  output logic [2*BYTE_W-1:0] hd_out,
  output logic                hd_lo_oe,
  output logic                hd_hi_oe,
  output logic                io16_n,
  output logic [ADDR_W-2:0]   ram_addr,
  output logic                ram_we_even,
  output logic                ram_we_odd,
  output logic [BYTE_W-1:0]   ram_wdata_even,
  output logic [BYTE_W-1:0]   ram_wdata_odd,
  input  logic [BYTE_W-1:0]   ram_rdata_even,
  input  logic [BYTE_W-1:0]   ram_rdata_odd
);

  // Named internal events, visible to the bound checker.
  logic  wide_q;
  logic  swap_q;
  logic  bsel_q;
  logic  lo_even;
  logic  rd_fire;
  logic  wr_fire;
  logic  cpu_wide;
  acc_t  acc;

  assign acc = '{rd: acc_rd, wr: acc_wr, ram: acc_ram, dma: acc_dma};

  lsu_cfg_regs #(
    .ADDR_W  (ADDR_W),
    .CTL_W   (8),
    .WIDE_BIT(WIDE_BIT)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .ptr_wr     (ptr_wr),
    .ptr_wdata  (ptr_wdata),
    .wide_o     (wide_q),
    .swap_o     (swap_q),
    .bsel_o     (bsel_q),
    .word_addr_o(ram_addr)
  );

  assign lo_even  = lower_is_even(host_style_e'(host_style), wide_q, swap_q, bsel_q);
  assign rd_fire  = read_fires(acc);
  assign wr_fire  = write_fires(acc);
  assign cpu_wide = wide_cpu_cycle(acc, wide_q);
  assign io16_n   = ~cpu_wide;

  lsu_read_steer #(.BYTE_W(BYTE_W)) u_rd (
    .rd_fire   (rd_fire),
    .wide      (wide_q),
    .lo_even   (lo_even),
    .rdata_even(ram_rdata_even),
    .rdata_odd (ram_rdata_odd),
    .dout      (hd_out),
    .lo_oe     (hd_lo_oe),
    .hi_oe     (hd_hi_oe)
  );

  lsu_write_steer #(.BYTE_W(BYTE_W)) u_wr (
    .wr_fire   (wr_fire),
    .wide      (wide_q),
    .lo_even   (lo_even),
    .din       (hd_in),
    .we_even   (ram_we_even),
    .we_odd    (ram_we_odd),
    .wdata_even(ram_wdata_even),
    .wdata_odd (ram_wdata_odd)
  );

endmodule

// File: rtl/lsu_checker.sv
module lsu_checker #(
  parameter int ADDR_W   = 11,
  parameter int BYTE_W   = 8,
  parameter int WIDE_BIT = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ctl_wr,
  input logic [7:0]          ctl_wdata,
  input logic                host_style,
  input logic                acc_rd,
  input logic                acc_wr,
  input logic                acc_ram,
  input logic                acc_dma,
  input logic [2*BYTE_W-1:0] hd_out,
  input logic                hd_lo_oe,
  input logic                hd_hi_oe,
  input logic                io16_n,
  input logic                ram_we_even,
  input logic                ram_we_odd,
  input logic [BYTE_W-1:0]   ram_rdata_even,
  input logic [BYTE_W-1:0]   ram_rdata_odd,
  input logic                wide_q,
  input logic                swap_q
);

  logic wide_rd;
  assign wide_rd = wide_q && acc_ram && acc_rd;

  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> wide_q == $past(ctl_wdata[WIDE_BIT])); // R2
  AST_NARROW_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |-> !(ram_we_even && ram_we_odd)); // R4
  AST_WIDE_BOTH_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_q && acc_ram && acc_wr && !acc_rd) |-> (ram_we_even && ram_we_odd)); // R5
  AST_STROBE_SWAP0: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_rd && !host_style && !swap_q) |->
      (hd_out[BYTE_W-1:0] == ram_rdata_even && hd_out[2*BYTE_W-1:BYTE_W] == ram_rdata_odd)); // R6
  AST_DIRDS_SWAP0: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_rd && host_style && !swap_q) |->
      (hd_out[BYTE_W-1:0] == ram_rdata_odd && hd_out[2*BYTE_W-1:BYTE_W] == ram_rdata_even)); // R7
  AST_NARROW_HI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |-> (!hd_hi_oe && hd_out[2*BYTE_W-1:BYTE_W] == '0)); // R8
  AST_IO16_WIDE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_rd && !acc_dma) |-> !io16_n); // R9
  AST_DMA_NO_IO16: assert property (@(posedge clk) disable iff (!rst_n)
    acc_dma |-> io16_n); // R10
  AST_NONRAM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ram |-> (!ram_we_even && !ram_we_odd && !hd_lo_oe && !hd_hi_oe)); // R11
  AST_READ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |-> (!ram_we_even && !ram_we_odd)); // R12

endmodule

bind byte_lane_steer lsu_checker #(
  .ADDR_W  (ADDR_W),
  .BYTE_W  (BYTE_W),
  .WIDE_BIT(WIDE_BIT)
) u_lsu_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctl_wr        (ctl_wr),
  .ctl_wdata     (ctl_wdata),
  .host_style    (host_style),
  .acc_rd        (acc_rd),
  .acc_wr        (acc_wr),
  .acc_ram       (acc_ram),
  .acc_dma       (acc_dma),
  .hd_out        (hd_out),
  .hd_lo_oe      (hd_lo_oe),
  .hd_hi_oe      (hd_hi_oe),
  .io16_n        (io16_n),
  .ram_we_even   (ram_we_even),
  .ram_we_odd    (ram_we_odd),
  .ram_rdata_even(ram_rdata_even),
  .ram_rdata_odd (ram_rdata_odd),
  .wide_q        (wide_q),
  .swap_q        (swap_q)
);

// File: tb/byte_lane_steer_tb.sv
`timescale 1ns/1ps
module byte_lane_steer_tb;
  localparam int ADDR_W = 11;
  localparam int NB     = 1 << ADDR_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic              ctl_wr;
  logic [7:0]        ctl_wdata;
  logic              ptr_wr;
  logic [ADDR_W-1:0] ptr_wdata;
  logic              host_style, acc_rd, acc_wr, acc_ram, acc_dma;
  logic [15:0]       hd_in, hd_out;
  logic              hd_lo_oe, hd_hi_oe, io16_n;
  logic [ADDR_W-2:0] ram_addr;
  logic              ram_we_even, ram_we_odd;
  logic [7:0]        ram_wdata_even, ram_wdata_odd, ram_rdata_even, ram_rdata_odd;

  byte_lane_steer u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .host_style(host_style),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_ram(acc_ram), .acc_dma(acc_dma),
    .hd_in(hd_in), .hd_out(hd_out), .hd_lo_oe(hd_lo_oe), .hd_hi_oe(hd_hi_oe),
    .io16_n(io16_n), .ram_addr(ram_addr), .ram_we_even(ram_we_even),
    .ram_we_odd(ram_we_odd), .ram_wdata_even(ram_wdata_even),
    .ram_wdata_odd(ram_wdata_odd), .ram_rdata_even(ram_rdata_even),
    .ram_rdata_odd(ram_rdata_odd)
  );

  // Byte-addressed RAM model: byte address = {word, bank}.
  logic [7:0] mem [0:NB-1];
  logic [7:0] ref_mem [0:NB-1];
  assign ram_rdata_even = mem[{ram_addr, 1'b0}];
  assign ram_rdata_odd  = mem[{ram_addr, 1'b1}];

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem[i] <= pat(i);
    end else begin
      if (ram_we_even) mem[{ram_addr, 1'b0}] <= ram_wdata_even;
      if (ram_we_odd)  mem[{ram_addr, 1'b1}] <= ram_wdata_odd;
    end
  end

  int checks = 0;
  int errors = 0;
  logic [15:0] o_out;
  logic        o_lo, o_hi, o_io16, o_we_e, o_we_o;
  logic [ADDR_W-2:0] o_addr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic set_ptr(input logic [ADDR_W-1:0] v);
    @(negedge clk); ptr_wr = 1'b1; ptr_wdata = v;
    @(negedge clk); ptr_wr = 1'b0;
  endtask

  task automatic acc(input logic rd, input logic wr, input logic ram, input logic dma,
                     input logic [15:0] din);
    @(negedge clk);
    acc_rd = rd; acc_wr = wr; acc_ram = ram; acc_dma = dma; hd_in = din;
    #1;
    o_out = hd_out; o_lo = hd_lo_oe; o_hi = hd_hi_oe; o_io16 = io16_n;
    o_we_e = ram_we_even; o_we_o = ram_we_odd; o_addr = ram_addr;
    @(posedge clk); #1;
    acc_rd = 0; acc_wr = 0; acc_ram = 0; acc_dma = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] ptrs [8];
    logic [ADDR_W-2:0] words [5];
    ptrs  = '{11'd0, 11'd1, 11'd2, 11'd3, 11'd2047, 11'd2046, 11'd1234, 11'd5};
    words = '{10'd0, 10'd1, 10'd511, 10'd1023, 10'd700};
    rst_n = 0; ctl_wr = 0; ctl_wdata = 0; ptr_wr = 0; ptr_wdata = 0;
    host_style = 0; acc_rd = 0; acc_wr = 0; acc_ram = 0; acc_dma = 0; hd_in = 0;
    repeat (3) @(posedge clk);
    for (int i = 0; i < NB; i++) ref_mem[i] = pat(i);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 lo_oe idle", hd_lo_oe, 0);
    chk("R1 hi_oe idle", hd_hi_oe, 0);
    chk("R1 io16_n idle", io16_n, 1);
    chk("R1 no write", {ram_we_even, ram_we_odd}, 0);
    acc(1, 0, 1, 0, 16'h0);
    chk("R1 narrow at reset, byte 0", o_out, {8'h00, ref_mem[0]});
    chk("R1 hi_oe narrow", o_hi, 0);

    // Narrow sweep
    for (int st = 0; st < 2; st++) begin
      for (int d = 0; d < 2; d++) begin
        for (int k = 0; k < 8; k++) begin
          logic [ADDR_W-1:0] p;
          logic [7:0] nb;
          p = ptrs[k];
          host_style = st[0];
          set_ptr(p);
          acc(1, 0, 1, d[0], 16'hFFFF);
          chk(d ? "R10 narrow dma read" : "R3 narrow read", o_out, {8'h00, ref_mem[p]});
          chk("R3 narrow addr", o_addr, p >> 1);
          chk("R8 narrow oes", {o_lo, o_hi}, 2'b10);
          chk("R9 narrow io16_n", o_io16, 1);
          nb = 8'(p * 5 + st * 17 + d * 91 + 3);
          acc(0, 1, 1, d[0], {~nb, nb});
          ref_mem[p] = nb;
          chk("R4 narrow write target", mem[p], ref_mem[p]);
          chk("R4 narrow neighbour untouched", mem[p ^ 1], ref_mem[p ^ 1]);
          chk("R9 narrow write io16_n", o_io16, 1);
        end
      end
    end

    // Wide mode; junk in other control bits
    set_ctl(8'hB5);
    #1;
    chk("R1 idle wide oes", {hd_lo_oe, hd_hi_oe}, 0);
    chk("R9 idle wide io16_n", io16_n, 1);
    for (int st = 0; st < 2; st++) begin
      for (int sw = 0; sw < 2; sw++) begin
        for (int d = 0; d < 2; d++) begin
          for (int k = 0; k < 5; k++) begin
            logic [ADDR_W-2:0] w;
            logic lp;
            logic [15:0] dv;
            string tag;
            w = words[k];
            lp = st[0] ^ sw[0];
            tag = d ? "R10" : (st ? "R7" : "R6");
            host_style = st[0];
            set_ptr({w, sw[0]});
            acc(1, 0, 1, d[0], 16'h0);
            chk({tag, " wide read lanes"}, o_out, {ref_mem[{w, ~lp}], ref_mem[{w, lp}]});
            chk("R5 wide addr ignores swap", o_addr, w);
            chk("R8 wide oes", {o_lo, o_hi}, 2'b11);
            chk("R9 wide read io16_n", o_io16, d[0]);
            dv = 16'((w * 13 + st * 7 + sw * 29 + d * 3) * 257 + 16'h1234);
            acc(0, 1, 1, d[0], dv);
            ref_mem[{w, lp}]  = dv[7:0];
            ref_mem[{w, ~lp}] = dv[15:8];
            chk("R5 wide both banks", {o_we_e, o_we_o}, 2'b11);
            chk({tag, " wide write lower"}, mem[{w, lp}], ref_mem[{w, lp}]);
            chk({tag, " wide write upper"}, mem[{w, ~lp}], ref_mem[{w, ~lp}]);
            chk("R9 wide write io16_n", o_io16, d[0]);
          end
        end
      end
    end

    // Non-RAM accesses in wide mode
    host_style = 0;
    set_ptr({10'd9, 1'b0});
    acc(1, 0, 0, 0, 16'h0);
    chk("R11 non-RAM read oes", {o_lo, o_hi}, 0);
    chk("R11 non-RAM read data", o_out, 0);
    chk("R9 non-RAM io16_n", o_io16, 1);
    acc(0, 1, 0, 0, 16'hDEAD);
    chk("R11 non-RAM write enables", {o_we_e, o_we_o}, 0);
    chk("R11 non-RAM write even", mem[{10'd9, 1'b0}], ref_mem[{10'd9, 1'b0}]);
    chk("R11 non-RAM write odd", mem[{10'd9, 1'b1}], ref_mem[{10'd9, 1'b1}]);

    // Read and write strobes together
    acc(1, 1, 1, 0, 16'hBEEF);
    chk("R12 read wins enables", {o_we_e, o_we_o}, 0);
    chk("R12 read wins data", o_out, {ref_mem[{10'd9, 1'b1}], ref_mem[{10'd9, 1'b0}]});
    chk("R12 even untouched", mem[{10'd9, 1'b0}], ref_mem[{10'd9, 1'b0}]);
    chk("R12 odd untouched", mem[{10'd9, 1'b1}], ref_mem[{10'd9, 1'b1}]);

    // Back to narrow with other control bits set
    set_ctl(8'h7F);
    set_ptr(11'd19);
    acc(1, 0, 1, 0, 16'h0);
    chk("R2 narrow again oes", {o_lo, o_hi}, 2'b10);
    chk("R2 narrow again data", o_out, {8'h00, ref_mem[19]});
    chk("R2 narrow io16_n", o_io16, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule